// File: doc/BRIEF.md
# Clock Configuration and Lock Status Controller

This block holds the 3-bit clock mode field of a chip's clock generator and tracks whether an external PLL has locked for that mode. Software writes the mode through a small register write port. A change into a PLL mode drops the lock flag and raises a PLL interrupt request. The lock flag comes back only when the PLL model reports lock again. The two non-PLL codes, direct drive and prescaler, never show lock. A missing-oscillator indication raises the same request and leaves the mode alone.

The request bit and its enable bit share one interrupt node register. Software updates that register with a masked write. After software issues the init-end command, the mode register is frozen. Each later change to the mode needs a two-write key sequence first.

Top module: `clk_cfg_ctrl`

## Requirements
- R1: After reset, cfg_o is 3'b001, and lock_o, irq_req_o, irq_o and cfg_locked_o are all 0. The enable bit is 0.
- R2: An accepted write to the mode register (address 0, wr_data_i[2:0]) with a value different from cfg_o selects that value. If the new value is a PLL code (any code except 001 and 011), lock_o reads 0 and irq_req_o reads 1 on the following cycle.
- R3: Writing the value cfg_o already holds leaves cfg_o, lock_o and irq_req_o unchanged.
- R4: Codes 001 (direct drive) and 011 (prescaler) never show lock_o = 1, whatever pll_lock_i does. Changing into either code raises no request.
- R5: In a PLL mode, a rising pll_lock_i sets lock_o one cycle later. A falling pll_lock_i clears it one cycle later. While pll_lock_i stays high after a mode change, lock_o stays 0 until pll_lock_i falls and rises again.
- R6: The interrupt node register is at address 2. Bit 0 is the request and bit 1 is the enable. A write updates only the bits set in wr_mask_i[1:0], taking the values from wr_data_i[1:0]. A hardware request in the same cycle wins over a software clear.
- R7: irq_o is 1 exactly when both the request bit and the enable bit are 1.
- R8: Writing 8'hE5 to address 1 (init-end) sets cfg_locked_o. While cfg_locked_o is 1, writes to the mode register are ignored.
- R9: Two consecutive writes to address 1 of 8'hA5 and then 8'h5A clear cfg_locked_o until the next write of any kind. If that next write is a mode write, it is accepted. Any other write between the two keys aborts the sequence.
- R10: osc_miss_i = 1 sets the request bit on the next cycle and leaves cfg_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mode, 1 key/command, 2 interrupt node |
| wr_data_i | input | 8 | Write data |
| wr_mask_i | input | 2 | Bit mask for interrupt node writes |
| pll_lock_i | input | 1 | Lock indication from the external PLL |
| osc_miss_i | input | 1 | Missing-oscillator indication |
| cfg_o | output | 3 | Current clock mode field |
| lock_o | output | 1 | PLL lock flag |
| irq_req_o | output | 1 | PLL interrupt request bit |
| irq_o | output | 1 | Gated interrupt line |
| cfg_locked_o | output | 1 | Mode register write-protected |

## Verification
A mode register that kept a stale value shows on cfg_o and in the request bit on the cycle after the write. The bench sweeps every pair of old and new codes to expose that. A lock flag that is wrong for the current mode shows on lock_o one cycle after the mode or pll_lock_i changes. A protection state machine stuck in the wrong state shows as a mode write that is wrongly accepted or wrongly refused. That error appears on the first mode write after init-end, after the key sequence, or after an aborted key sequence.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int CFG_W  = 3;
  localparam int DW     = 8;
  localparam int AW     = 2;
  localparam int IRQ_W  = 2;
  localparam int IRQ_REQ_BIT = 0;
  localparam int IRQ_EN_BIT  = 1;

  localparam logic [AW-1:0] ADDR_CFG = 2'd0;
  localparam logic [AW-1:0] ADDR_KEY = 2'd1;
  localparam logic [AW-1:0] ADDR_IRQ = 2'd2;

  localparam logic [DW-1:0] KEY_INIT = 8'hE5;
  localparam logic [DW-1:0] KEY_A    = 8'hA5;
  localparam logic [DW-1:0] KEY_B    = 8'h5A;

  localparam logic [CFG_W-1:0] CFG_DIRECT    = 3'b001;
  localparam logic [CFG_W-1:0] CFG_PRESCALER = 3'b011;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} ul_state_e;

  function automatic logic is_pll_mode(input logic [CFG_W-1:0] c);
    return !(c == CFG_DIRECT || c == CFG_PRESCALER);
  endfunction
endpackage

// File: rtl/clk_cfg_unlock.sv
module clk_cfg_unlock
  import clk_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          cfg_locked_o
);
  ul_state_e state_q, state_d;
  logic      done_q, done_d;
  logic      key_wr;

  assign key_wr = wr_en_i && (wr_addr_i == ADDR_KEY);

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    if (wr_en_i) begin
      state_d = UL_IDLE;
      if (key_wr && wr_data_i == KEY_INIT) done_d = 1'b1;
      else if (key_wr && wr_data_i == KEY_A && state_q == UL_IDLE) state_d = UL_HALF;
      else if (key_wr && wr_data_i == KEY_B && state_q == UL_HALF) state_d = UL_OPEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= UL_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign cfg_locked_o = done_q && (state_q != UL_OPEN);

  // R8
  a_r8_init_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr && wr_data_i == KEY_INIT |=> cfg_locked_o);
  // R9: a key pair opens exactly one window
  a_r9_window_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_locked_o && done_q && wr_en_i && !(key_wr && wr_data_i == KEY_INIT) |=> cfg_locked_o);
endmodule

// File: rtl/clk_cfg_core.sv
module clk_cfg_core
  import clk_cfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = CFG_DIRECT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             pll_lock_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             lock_o,
  output logic             req_set_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             lock_q, lock_d, pll_prev_q, changed;

  assign changed   = cfg_we_i && (cfg_wdata_i != cfg_q);
  assign req_set_o = changed && is_pll_mode(cfg_wdata_i);

  always_comb begin
    if (changed || !is_pll_mode(cfg_q)) lock_d = 1'b0;
    else lock_d = pll_lock_i && (lock_q || !pll_prev_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= RST_CFG;
      lock_q     <= 1'b0;
      pll_prev_q <= 1'b0;
    end else begin
      if (changed) cfg_q <= cfg_wdata_i;
      lock_q     <= lock_d;
      pll_prev_q <= pll_lock_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign lock_o = lock_q;

  // R2
  a_r2_change_drops_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_wdata_i != cfg_o && is_pll_mode(cfg_wdata_i) |=> !lock_o);
  // R3
  a_r3_same_value_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_wdata_i == cfg_o |=> $stable(cfg_o) && $stable(lock_o));
  // R4
  a_r4_direct_never_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_pll_mode(cfg_o) |-> !lock_o);
endmodule

// File: rtl/clk_cfg_irq.sv
module clk_cfg_irq
  import clk_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             sw_we_i,
  input  logic [IRQ_W-1:0] sw_data_i,
  input  logic [IRQ_W-1:0] sw_mask_i,
  output logic             req_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] node_q, node_d;

  always_comb begin
    node_d = node_q;
    if (sw_we_i) node_d = (node_q & ~sw_mask_i) | (sw_data_i & sw_mask_i);
    if (set_i) node_d[IRQ_REQ_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) node_q <= '0;
    else         node_q <= node_d;
  end

  assign req_o = node_q[IRQ_REQ_BIT];
  assign irq_o = node_q[IRQ_REQ_BIT] & node_q[IRQ_EN_BIT];

  // R6: hardware set wins over a software clear
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> req_o);
  // R6: unmasked bits keep their value
  a_r6_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i && !sw_mask_i[IRQ_REQ_BIT] && !set_i |=> $stable(req_o));
endmodule

// File: rtl/clk_cfg_ctrl.sv
module clk_cfg_ctrl
  import clk_cfg_pkg::*;
#(
  parameter logic [2:0] RST_CFG = 3'b001
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] wr_mask_i,
  input  logic       pll_lock_i,
  input  logic       osc_miss_i,
  output logic [2:0] cfg_o,
  output logic       lock_o,
  output logic       irq_req_o,
  output logic       irq_o,
  output logic       cfg_locked_o
);
  logic cfg_we, irq_we, req_set;

  assign cfg_we = wr_en_i && (wr_addr_i == ADDR_CFG) && !cfg_locked_o;
  assign irq_we = wr_en_i && (wr_addr_i == ADDR_IRQ);

  clk_cfg_unlock u_unlock (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cfg_locked_o
  );

  clk_cfg_core #(.RST_CFG(RST_CFG)) u_core (
    .clk_i, .rst_ni,
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(wr_data_i[CFG_W-1:0]),
    .pll_lock_i,
    .cfg_o,
    .lock_o,
    .req_set_o  (req_set)
  );

  clk_cfg_irq u_irq (
    .clk_i, .rst_ni,
    .set_i    (req_set | osc_miss_i),
    .sw_we_i  (irq_we),
    .sw_data_i(wr_data_i[IRQ_W-1:0]),
    .sw_mask_i(wr_mask_i),
    .req_o    (irq_req_o),
    .irq_o
  );

  // R8
  a_r8_locked_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_locked_o && wr_en_i && wr_addr_i == ADDR_CFG |=> $stable(cfg_o));
  // R10
  a_r10_osc_sets_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_miss_i && !(wr_en_i && wr_addr_i == ADDR_CFG) |=> irq_req_o && $stable(cfg_o));
  // R7
  a_r7_line_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_req_o);
endmodule

// File: tb/sim_clk_cfg_ctrl.sv
module sim_clk_cfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_mask = '0;
  logic       pll_lock = 1'b0;
  logic       osc_miss = 1'b0;
  logic [2:0] cfg;
  logic       lock, irq_req, irq, cfg_locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_cfg_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_mask_i(wr_mask), .pll_lock_i(pll_lock),
    .osc_miss_i(osc_miss), .cfg_o(cfg), .lock_o(lock), .irq_req_o(irq_req),
    .irq_o(irq), .cfg_locked_o(cfg_locked)
  );

  function automatic bit pll_code(input logic [2:0] c);
    return !(c == 3'b001 || c == 3'b011);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [1:0] m = 2'b00);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_req();
    wr(2'd2, 8'h00, 2'b01);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(WATCHDOG);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R1 reset state
    chk("R1 cfg", {5'd0, cfg}, 8'h01);
    chk("R1 lock", {7'd0, lock}, 0);
    chk("R1 req", {7'd0, irq_req}, 0);
    chk("R1 irq", {7'd0, irq}, 0);
    chk("R1 locked", {7'd0, cfg_locked}, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 cfg after release", {5'd0, cfg}, 8'h01);

    // R2 R3 R4: sweep every old/new code pair, PLL unlocked
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        wr(2'd0, 8'(a));
        clr_req();
        wr(2'd0, 8'(b));
        chk(a == b ? "R3 sweep cfg" : "R2 sweep cfg", {5'd0, cfg}, 8'(b));
        chk(a == b ? "R3 sweep req" : (pll_code(3'(b)) ? "R2 sweep req" : "R4 sweep req"),
            {7'd0, irq_req}, {7'd0, (a != b) && pll_code(3'(b))});
        chk("R4 sweep lock", {7'd0, lock}, 0);
      end
    end

    // R5 lock regained in PLL mode
    wr(2'd0, 8'h00); clr_req();
    @(negedge clk); pll_lock = 1'b1;
    @(negedge clk);
    chk("R5 lock set", {7'd0, lock}, 1);
    // R3 same value keeps lock
    wr(2'd0, 8'h00);
    chk("R3 same keeps lock", {7'd0, lock}, 1);
    chk("R3 same no req", {7'd0, irq_req}, 0);
    // R2 change with PLL still high: lock drops, stays dropped
    wr(2'd0, 8'h04);
    chk("R2 change drops lock", {7'd0, lock}, 0);
    chk("R2 change req", {7'd0, irq_req}, 1);
    idle(3);
    chk("R5 no relock without edge", {7'd0, lock}, 0);
    pll_lock = 1'b0; @(negedge clk); pll_lock = 1'b1; @(negedge clk);
    chk("R5 relock on edge", {7'd0, lock}, 1);
    pll_lock = 1'b0; @(negedge clk);
    chk("R5 lock follows fall", {7'd0, lock}, 0);
    // R4 direct/prescaler never lock
    wr(2'd0, 8'h01);
    pll_lock = 1'b1; idle(3);
    chk("R4 direct no lock", {7'd0, lock}, 0);
    wr(2'd0, 8'h03);
    pll_lock = 1'b0; @(negedge clk); pll_lock = 1'b1; idle(2);
    chk("R4 prescaler no lock", {7'd0, lock}, 0);
    pll_lock = 1'b0;

    // R6 R7 interrupt node
    clr_req();
    chk("R6 clear req", {7'd0, irq_req}, 0);
    wr(2'd2, 8'h01, 2'b01);
    chk("R7 req no en", {7'd0, irq}, 0);
    wr(2'd2, 8'h02, 2'b10);
    chk("R6 mask keeps req", {7'd0, irq_req}, 1);
    chk("R7 req and en", {7'd0, irq}, 1);
    wr(2'd2, 8'h00, 2'b11);
    chk("R7 both cleared", {7'd0, irq}, 0);
    wr(2'd2, 8'h02, 2'b10);
    chk("R7 en only", {7'd0, irq}, 0);
    // R10 osc missing, and R6 set wins over clear
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00; wr_mask = 2'b01; osc_miss = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; osc_miss = 1'b0;
    chk("R6 set wins", {7'd0, irq_req}, 1);
    chk("R10 cfg unchanged", {5'd0, cfg}, 8'h03);
    chk("R7 irq line", {7'd0, irq}, 1);
    clr_req();
    @(negedge clk); osc_miss = 1'b1; @(negedge clk); osc_miss = 1'b0;
    chk("R10 osc sets req", {7'd0, irq_req}, 1);

    // R8 init-end locks
    wr(2'd1, 8'hE5);
    chk("R8 locked", {7'd0, cfg_locked}, 1);
    wr(2'd0, 8'h06);
    chk("R8 write ignored", {5'd0, cfg}, 8'h03);
    // R9 unlock sequence
    wr(2'd1, 8'hA5);
    chk("R9 half key locked", {7'd0, cfg_locked}, 1);
    wr(2'd1, 8'h5A);
    chk("R9 unlocked", {7'd0, cfg_locked}, 0);
    wr(2'd0, 8'h06);
    chk("R9 write accepted", {5'd0, cfg}, 8'h06);
    chk("R9 relocked", {7'd0, cfg_locked}, 1);
    wr(2'd0, 8'h01);
    chk("R9 second write ignored", {5'd0, cfg}, 8'h06);
    // R9 abort by intervening access
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h00, 2'b00);
    wr(2'd1, 8'h5A);
    chk("R9 abort stays locked", {7'd0, cfg_locked}, 1);
    wr(2'd0, 8'h01);
    chk("R9 abort write ignored", {5'd0, cfg}, 8'h06);
    // R9 window closed by non-mode write
    wr(2'd1, 8'hA5); wr(2'd1, 8'h5A);
    wr(2'd2, 8'h00, 2'b00);
    wr(2'd0, 8'h01);
    chk("R9 window consumed", {5'd0, cfg}, 8'h06);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule